// File: doc/BRIEF.md
# GPIO Controller with Peripheral Pin Sharing

This block is a register-mapped general-purpose I/O controller for a 16-bit register bus. It owns two banks of pads: a full 16-pin bank and a narrower upper bank. Software sets the output level and the drive direction of each pin. It reads pad levels through input registers that are separate from the output registers, so reading an output register always returns the value that was stored there.

A mux-control register can lend groups of bank-0 pins to two on-chip serial ports. The top nibble (pins 15..12) can go to a high-speed serial port. Pins 11..8 can go to an SPI port. A lent pin takes its level and its enable from the peripheral. That peripheral then sees the pad level on its input.

A select-relocation bit moves the SPI slave-select input from pin 8 to pin 15. When the relocation is active, it takes pin 15 away from the high-speed port.

One external interrupt line passes through a synchronizer and an edge detector. The edge is either rising or falling, chosen by software. A detected edge sets a sticky pending flag. The request output is asserted only while the local enable and the global GPIO interrupt enable are both set.

The register bus is a plain single-cycle register interface, not a stream:
- A write happens on the clock edge at which `bus_en` and `bus_we` are both high.
- Read data is combinational from `bus_addr`.
- There is no back-pressure.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_out0`/`pad_oe0`/`pad_out1`/`pad_oe1` are 0 and `irq_req` is 0.
- R2: Registers and addresses are as follows:
  - Output data bank 0 is at 0xC01E and output data bank 1 is at 0xC024. Each reads back the last value written, whatever the pad levels are.
  - Input registers at 0xC020 (bank 0) and 0xC026 (bank 1) return the current pad levels.
  - Direction registers are at 0xC022 (bank 0) and 0xC028 (bank 1).
- R3: On a pin owned by GPIO, the pad level equals the output-data bit: 1 drives high and 0 drives low. The pad enable equals the direction bit, where 1 means drive.
- R4: Bank 1 implements bits 12..0 only, so bits 15..13 read 0. Unused bits of the mux-control register (0xC006), the interrupt-control register (0xC00E) and the global enable register (0xC00C) ignore writes and read 0.
- R5: When mux-control bit 7 is 1, pins 15..12 take `hss_out`/`hss_oe` and `hss_in` follows those pads. When bit 7 is 0, the pins are GPIO and `hss_in` is 0.
- R6: When mux-control bit 5 is 1, pins 11..8 take `spi_out`/`spi_oe` and `spi_in` follows those pads. When bit 5 is 0, the pins are GPIO and `spi_in` is 0.
- R7: When mux-control bits 6 and 5 are both 1, the following holds:
  - `spi_in[0]` (slave select) comes from pin 15.
  - Pin 15 is undriven even if bit 7 is set, and `hss_in[3]` is 0.
  - Pin 8 returns to GPIO.
- R8: Output-data bits of a lent pin are kept. They drive the pad again once the pin returns to GPIO.
- R9: Interrupt-control bit 1 selects the edge: 1 is rising and 0 is falling. A selected edge on `irq_pin` sets the pending flag (status register 0xC010, bit 0) within 4 clocks. Edges of the other polarity are ignored.
- R10: `irq_req` is the pending flag ANDed with the interrupt-control bit 0 and global-enable bit 4. The pending flag stays set until software writes 1 to status bit 0.
- R11: Edges that arrive while interrupt-control bit 0 is 0 do not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pad_in0 | input | 16 | Bank 0 pad levels |
| pad_out0 | output | 16 | Bank 0 pad output level |
| pad_oe0 | output | 16 | Bank 0 pad drive enable |
| pad_in1 | input | 13 | Bank 1 pad levels |
| pad_out1 | output | 13 | Bank 1 pad output level |
| pad_oe1 | output | 13 | Bank 1 pad drive enable |
| hss_out | input | 4 | High-speed port output levels |
| hss_oe | input | 4 | High-speed port drive enables |
| hss_in | output | 4 | High-speed port input levels |
| spi_out | input | 4 | SPI port output levels |
| spi_oe | input | 4 | SPI port drive enables |
| spi_in | output | 4 | SPI port inputs, bit 0 is slave select |
| irq_pin | input | 1 | External interrupt line |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench checks that an output register still returns its stored value while the pad shows something else; a design that looped pad levels into that readback would fail there. Select relocation is checked with the high-speed port also enabled on pin 15. A wrong priority would leave pin 15 driven by the high-speed port, or would leave pin 8 captured by the SPI port. The interrupt path gets edges of the wrong polarity, edges arriving while the local enable is off, and the global enable withdrawn while a request is pending. These tests catch an edge detector without a polarity check, a pending flag that is not sticky, and a request that ignores one of its two enables.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;

  localparam logic [AW-1:0] A_CTRL   = 16'hC006;
  localparam logic [AW-1:0] A_GIE    = 16'hC00C;
  localparam logic [AW-1:0] A_IRQC   = 16'hC00E;
  localparam logic [AW-1:0] A_STAT   = 16'hC010;
  localparam logic [AW-1:0] A_OUT0   = 16'hC01E;
  localparam logic [AW-1:0] A_IN0    = 16'hC020;
  localparam logic [AW-1:0] A_DIR0   = 16'hC022;
  localparam logic [AW-1:0] A_OUT1   = 16'hC024;
  localparam logic [AW-1:0] A_IN1    = 16'hC026;
  localparam logic [AW-1:0] A_DIR1   = 16'hC028;

  localparam int unsigned B_HSS_EN  = 7;
  localparam int unsigned B_SS_MOVE = 6;
  localparam int unsigned B_SPI_EN  = 5;
  localparam int unsigned B_IRQ_EN  = 0;
  localparam int unsigned B_IRQ_RISE = 1;
  localparam int unsigned B_GIE_GPIO = 4;
  localparam int unsigned B_PEND    = 0;

  typedef struct packed {
    logic hss_en;
    logic ss_move;
    logic spi_en;
  } mux_cfg_t;

  typedef struct packed {
    logic rise;
    logic en;
  } irq_cfg_t;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_HSS  = 2'd1,
    OWN_SPI  = 2'd2,
    OWN_SSIN = 2'd3
  } pin_owner_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int unsigned B0W = 16,
  parameter int unsigned B1W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [B0W-1:0] pad_in0,
  input  logic [B1W-1:0] pad_in1,
  input  logic           pend,
  output logic [B0W-1:0] out0_q,
  output logic [B0W-1:0] dir0_q,
  output logic [B1W-1:0] out1_q,
  output logic [B1W-1:0] dir1_q,
  output mux_cfg_t       mux_q,
  output irq_cfg_t       irqc_q,
  output logic           gie_q,
  output logic           pend_clr
);
  localparam int unsigned PAD0 = DW - B0W;
  localparam int unsigned PAD1 = DW - B1W;

  logic wr;
  assign wr = bus_en && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_q <= '0;
      dir0_q <= '0;
      out1_q <= '0;
      dir1_q <= '0;
      mux_q  <= '0;
      irqc_q <= '0;
      gie_q  <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        A_OUT0: out0_q <= bus_wdata[B0W-1:0];
        A_DIR0: dir0_q <= bus_wdata[B0W-1:0];
        A_OUT1: out1_q <= bus_wdata[B1W-1:0];
        A_DIR1: dir1_q <= bus_wdata[B1W-1:0];
        A_CTRL: begin
          mux_q.hss_en  <= bus_wdata[B_HSS_EN];
          mux_q.ss_move <= bus_wdata[B_SS_MOVE];
          mux_q.spi_en  <= bus_wdata[B_SPI_EN];
        end
        A_IRQC: begin
          irqc_q.rise <= bus_wdata[B_IRQ_RISE];
          irqc_q.en   <= bus_wdata[B_IRQ_EN];
        end
        A_GIE:  gie_q <= bus_wdata[B_GIE_GPIO];
        default: ;
      endcase
    end
  end

  assign pend_clr = wr && (bus_addr == A_STAT) && bus_wdata[B_PEND];

  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      case (bus_addr)
        A_OUT0: bus_rdata = {{PAD0{1'b0}}, out0_q};
        A_DIR0: bus_rdata = {{PAD0{1'b0}}, dir0_q};
        A_IN0:  bus_rdata = {{PAD0{1'b0}}, pad_in0};
        A_OUT1: bus_rdata = {{PAD1{1'b0}}, out1_q};
        A_DIR1: bus_rdata = {{PAD1{1'b0}}, dir1_q};
        A_IN1:  bus_rdata = {{PAD1{1'b0}}, pad_in1};
        A_CTRL: begin
          bus_rdata[B_HSS_EN]  = mux_q.hss_en;
          bus_rdata[B_SS_MOVE] = mux_q.ss_move;
          bus_rdata[B_SPI_EN]  = mux_q.spi_en;
        end
        A_IRQC: begin
          bus_rdata[B_IRQ_RISE] = irqc_q.rise;
          bus_rdata[B_IRQ_EN]   = irqc_q.en;
        end
        A_GIE:  bus_rdata[B_GIE_GPIO] = gie_q;
        A_STAT: bus_rdata[B_PEND] = pend;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NPIN    = 16,
  parameter int unsigned GW      = 4,
  parameter int unsigned HSS_LSB = 12,
  parameter int unsigned SPI_LSB = 8,
  parameter int unsigned SS_PIN  = 15
) (
  input  mux_cfg_t        cfg,
  input  logic [NPIN-1:0] gpio_out,
  input  logic [NPIN-1:0] gpio_dir,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic [GW-1:0]   hss_out,
  input  logic [GW-1:0]   hss_oe,
  output logic [GW-1:0]   hss_in,
  input  logic [GW-1:0]   spi_out,
  input  logic [GW-1:0]   spi_oe,
  output logic [GW-1:0]   spi_in
);
  localparam int unsigned HSS_MSB = HSS_LSB + GW - 1;
  localparam int unsigned SPI_MSB = SPI_LSB + GW - 1;
  localparam int unsigned EXT     = NPIN - GW;

  logic [NPIN-1:0] hss_o_w, hss_e_w, spi_o_w, spi_e_w;
  assign hss_o_w = {{EXT{1'b0}}, hss_out} << HSS_LSB;
  assign hss_e_w = {{EXT{1'b0}}, hss_oe}  << HSS_LSB;
  assign spi_o_w = {{EXT{1'b0}}, spi_out} << SPI_LSB;
  assign spi_e_w = {{EXT{1'b0}}, spi_oe}  << SPI_LSB;

  logic ss_moved;
  assign ss_moved = cfg.spi_en && cfg.ss_move;

  pin_owner_e owner [NPIN];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam bit IN_HSS = (p >= HSS_LSB) && (p <= HSS_MSB);
    localparam bit IN_SPI = (p >= SPI_LSB) && (p <= SPI_MSB);
    localparam bit IS_SS  = (p == SS_PIN);
    localparam bit IS_SS0 = (p == SPI_LSB);

    always_comb begin
      owner[p] = OWN_GPIO;
      if (IS_SS && ss_moved)
        owner[p] = OWN_SSIN;
      else if (IS_SS0 && ss_moved)
        owner[p] = OWN_GPIO;
      else if (IN_HSS && cfg.hss_en)
        owner[p] = OWN_HSS;
      else if (IN_SPI && cfg.spi_en)
        owner[p] = OWN_SPI;
    end

    always_comb begin
      case (owner[p])
        OWN_HSS: begin
          pad_out[p] = hss_o_w[p];
          pad_oe[p]  = hss_e_w[p];
        end
        OWN_SPI: begin
          pad_out[p] = spi_o_w[p];
          pad_oe[p]  = spi_e_w[p];
        end
        OWN_SSIN: begin
          pad_out[p] = 1'b0;
          pad_oe[p]  = 1'b0;
        end
        default: begin
          pad_out[p] = gpio_out[p];
          pad_oe[p]  = gpio_dir[p];
        end
      endcase
    end
  end

  for (genvar i = 0; i < GW; i++) begin : g_periph_in
    assign hss_in[i] = (owner[HSS_LSB+i] == OWN_HSS) ? pad_in[HSS_LSB+i] : 1'b0;
    if (i == 0) begin : g_ss
      assign spi_in[i] = ss_moved ? pad_in[SS_PIN] :
                         (owner[SPI_LSB] == OWN_SPI) ? pad_in[SPI_LSB] : 1'b0;
    end else begin : g_data
      assign spi_in[i] = (owner[SPI_LSB+i] == OWN_SPI) ? pad_in[SPI_LSB+i] : 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pin,
  input  logic rise_sel,
  input  logic local_en,
  input  logic global_en,
  input  logic clr,
  output logic pend_o,
  output logic irq_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            pend_q;
  logic            lvl, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], irq_pin};
  end

  assign lvl = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign hit = local_en && (rise_sel ? (lvl && !prev_q) : (!lvl && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && local_en && global_en;
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int unsigned B1W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [15:0]    bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  input  logic [15:0]    pad_in0,
  output logic [15:0]    pad_out0,
  output logic [15:0]    pad_oe0,
  input  logic [B1W-1:0] pad_in1,
  output logic [B1W-1:0] pad_out1,
  output logic [B1W-1:0] pad_oe1,
  input  logic [3:0]     hss_out,
  input  logic [3:0]     hss_oe,
  output logic [3:0]     hss_in,
  input  logic [3:0]     spi_out,
  input  logic [3:0]     spi_oe,
  output logic [3:0]     spi_in,
  input  logic           irq_pin,
  output logic           irq_req
);
  localparam int unsigned B0W = 16;

  logic [B0W-1:0] out0_q, dir0_q;
  logic [B1W-1:0] out1_q, dir1_q;
  mux_cfg_t       mux_q;
  irq_cfg_t       irqc_q;
  logic           gie_q, pend_q, pend_clr;

  gpio_regs #(.B0W(B0W), .B1W(B1W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in0(pad_in0), .pad_in1(pad_in1), .pend(pend_q),
    .out0_q(out0_q), .dir0_q(dir0_q), .out1_q(out1_q), .dir1_q(dir1_q),
    .mux_q(mux_q), .irqc_q(irqc_q), .gie_q(gie_q), .pend_clr(pend_clr)
  );

  gpio_pinmux #(.NPIN(B0W), .GW(4), .HSS_LSB(12), .SPI_LSB(8), .SS_PIN(15)) u_mux (
    .cfg(mux_q), .gpio_out(out0_q), .gpio_dir(dir0_q), .pad_in(pad_in0),
    .pad_out(pad_out0), .pad_oe(pad_oe0),
    .hss_out(hss_out), .hss_oe(hss_oe), .hss_in(hss_in),
    .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in)
  );

  assign pad_out1 = out1_q;
  assign pad_oe1  = dir1_q;

  gpio_irq #(.SYNC(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
    .rise_sel(irqc_q.rise), .local_en(irqc_q.en), .global_en(gie_q),
    .clr(pend_clr), .pend_o(pend_q), .irq_o(irq_req)
  );
endmodule

// File: rtl/gpio_mux_ctrl_sva.sv
module gpio_mux_ctrl_sva
  import gpio_mux_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [15:0] pad_in0,
  input logic [15:0] pad_out0,
  input logic [15:0] pad_oe0,
  input logic [15:0] out0_q,
  input logic [3:0]  hss_oe,
  input logic [3:0]  spi_in,
  input mux_cfg_t    mux_q,
  input irq_cfg_t    irqc_q,
  input logic        gie_q,
  input logic        pend_q,
  input logic        irq_req
);
  AST_IRQ_NEEDS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irqc_q.en && gie_q && pend_q)); // R10

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(bus_en && bus_we && bus_addr == A_STAT && bus_wdata[B_PEND])) |=> pend_q); // R10

  AST_HSS_OWNS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q.hss_en && !(mux_q.spi_en && mux_q.ss_move)) |-> (pad_oe0[15] == hss_oe[3])); // R5

  AST_SS_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q.spi_en && mux_q.ss_move) |-> (!pad_oe0[15] && spi_in[0] == pad_in0[15])); // R7

  AST_GPIO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_q.spi_en |-> (pad_out0[11:8] == out0_q[11:8])); // R3

  AST_BANK1_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == A_OUT1) |-> (bus_rdata[15:13] == 3'b000)); // R4
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in0(pad_in0), .pad_out0(pad_out0), .pad_oe0(pad_oe0),
  .out0_q(out0_q), .hss_oe(hss_oe), .spi_in(spi_in),
  .mux_q(mux_q), .irqc_q(irqc_q), .gie_q(gie_q), .pend_q(pend_q),
  .irq_req(irq_req)
);

// File: tb/gpio_mux_ctrl_tb.sv
module gpio_mux_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [15:0] pad_in0 = '0, pad_out0, pad_oe0;
  logic [12:0] pad_in1 = '0, pad_out1, pad_oe1;
  logic [3:0]  hss_out = '0, hss_oe = '0, hss_in;
  logic [3:0]  spi_out = '0, spi_oe = '0, spi_in;
  logic        irq_pin = 1'b0, irq_req;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_mux_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in0(pad_in0), .pad_out0(pad_out0), .pad_oe0(pad_oe0),
    .pad_in1(pad_in1), .pad_out1(pad_out1), .pad_oe1(pad_oe1),
    .hss_out(hss_out), .hss_oe(hss_oe), .hss_in(hss_in),
    .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in),
    .irq_pin(irq_pin), .irq_req(irq_req)
  );

  // {write address, write data, read address, expected read}
  localparam int NV = 7;
  localparam logic [63:0] VEC [NV] = '{
    {16'hC01E, 16'hA5C3, 16'hC01E, 16'hA5C3},  // R2
    {16'hC022, 16'h1234, 16'hC022, 16'h1234},  // R2
    {16'hC024, 16'hFFFF, 16'hC024, 16'h1FFF},  // R4
    {16'hC028, 16'hE001, 16'hC028, 16'h0001},  // R4
    {16'hC006, 16'hFFFF, 16'hC006, 16'h00E0},  // R4
    {16'hC00E, 16'hFFFF, 16'hC00E, 16'h0003},  // R4
    {16'hC00C, 16'hFFFF, 16'hC00C, 16'h0010}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    settle(2);
    // R1 reset state
    check("R1 pads", {pad_out0, pad_oe0}, 32'h0);
    check("R1 bank1", {pad_out1, pad_oe1}, 32'h0);
    check("R1 irq", irq_req, 0);
    rst_n = 1'b1;
    rd(16'hC01E, r); check("R1 out0", r, 0);
    rd(16'hC006, r); check("R1 ctrl", r, 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][63:48], VEC[v][47:32]);
      rd(VEC[v][31:16], r);
      check("R2/R4 table", r, VEC[v][15:0]);
    end

    wr(16'hC006, 16'h0000);
    wr(16'hC00E, 16'h0000);
    wr(16'hC00C, 16'h0000);

    // R3 GPIO drive
    wr(16'hC01E, 16'h5A5A);
    wr(16'hC022, 16'hFFFF);
    settle(1);
    check("R3 out", pad_out0, 16'h5A5A);
    check("R3 oe", pad_oe0, 16'hFFFF);
    wr(16'hC028, 16'h1FFF);
    wr(16'hC024, 16'h0F0F);
    check("R3 bank1", {pad_out1, pad_oe1}, {13'h0F0F, 13'h1FFF});

    // R2 readback independence
    pad_in0 = 16'h0F0F;
    rd(16'hC020, r); check("R2 in0", r, 16'h0F0F);
    rd(16'hC01E, r); check("R2 out0 kept", r, 16'h5A5A);
    pad_in1 = 13'h0ABC;
    rd(16'hC026, r); check("R2 in1", r, 16'h0ABC);

    // R5 high-speed port
    hss_out = 4'b1010; hss_oe = 4'b0110; pad_in0 = 16'hF000;
    wr(16'hC006, 16'h0080);
    check("R5 out", pad_out0, 16'hAA5A);
    check("R5 oe", pad_oe0, 16'h6FFF);
    check("R5 in", hss_in, 4'hF);
    check("R6 spi_in idle", spi_in, 4'h0);

    // R6 SPI port
    spi_out = 4'b0011; spi_oe = 4'b1111; pad_in0 = 16'h0500;
    wr(16'hC006, 16'h0020);
    check("R6 out", pad_out0, 16'h535A);
    check("R6 oe", pad_oe0, 16'hFFFF);
    check("R6 in", spi_in, 4'h5);
    check("R5 hss_in idle", hss_in, 4'h0);

    // R7 select relocation over high-speed port
    spi_oe = 4'b0000; hss_oe = 4'b1111; pad_in0 = 16'h8000;
    wr(16'hC006, 16'h00E0);
    check("R7 ss", spi_in[0], 1'b1);
    check("R7 pin15 oe", pad_oe0[15], 1'b0);
    check("R7 hss_in3", hss_in[3], 1'b0);
    check("R7 pin8 gpio", {pad_oe0[11:8], pad_out0[8]}, {4'b0001, 1'b0});
    pad_in0 = 16'h0100;
    #1 check("R7 ss from 15 not 8", spi_in[0], 1'b0);

    // R8 data kept while lent
    wr(16'hC006, 16'h0000);
    check("R8 pads back", pad_out0, 16'h5A5A);
    rd(16'hC01E, r); check("R8 reg", r, 16'h5A5A);

    // R11 edges while disabled
    wr(16'hC00C, 16'h0010);
    irq_pin = 1'b1; settle(4);
    irq_pin = 1'b0; settle(4);
    rd(16'hC010, r); check("R11 no pend", r, 0);

    // R9 rising selected
    wr(16'hC00E, 16'h0003);
    irq_pin = 1'b1; settle(4);
    rd(16'hC010, r); check("R9 rise pend", r, 16'h0001);
    check("R10 irq", irq_req, 1'b1);
    wr(16'hC010, 16'h0001);
    rd(16'hC010, r); check("R10 clear", r, 0);
    check("R10 irq low", irq_req, 1'b0);
    irq_pin = 1'b0; settle(4);
    rd(16'hC010, r); check("R9 fall ignored", r, 0);

    // R9 falling selected
    wr(16'hC00E, 16'h0001);
    irq_pin = 1'b1; settle(4);
    rd(16'hC010, r); check("R9 rise ignored", r, 0);
    irq_pin = 1'b0; settle(4);
    rd(16'hC010, r); check("R9 fall pend", r, 16'h0001);

    // R10 global enable gating and stickiness
    wr(16'hC00C, 16'h0000);
    check("R10 gie off", irq_req, 1'b0);
    settle(3);
    rd(16'hC010, r); check("R10 sticky", r, 16'h0001);
    wr(16'hC00C, 16'h0010);
    check("R10 gie on", irq_req, 1'b1);
    wr(16'hC010, 16'h0000);
    rd(16'hC010, r); check("R10 write0 keeps", r, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule